// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four external interrupt pins before they reach an interrupt prioritiser. Each pin goes through a two-flop synchroniser. It is then interpreted under a per-line sense type: active-high level, active-low level, rising edge or falling edge. In the edge modes a sticky latch holds the event until software clears it. A per-line enable and a single master enable gate the conditioned requests.

All configuration lives in one 32-bit control register. The bit positions are fixed, because the software that drives the block decodes them:

| Field | Bits |
|---|---|
| Sense field of line n | (23-2n):(22-2n) |
| Enable of line n | 11-n |
| Edge-latch clear of line n (write-one) | 27-n |
| Master enable | 12 |
| Critical-routing select | 0 |

Line 0 is presented as the critical-group request. Lines 1 to 3 are presented as main-group sources 1 to 3. Priority resolution between the groups happens downstream.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, every request output is 0 and `crit_normal` is 0.
- R2: A write stores sense codes at bits (23-2n):(22-2n), enables at bit 11-n, master enable at bit 12 and routing select at bit 0. Every other bit, including the clear bits 27:24, reads back as 0. Writing 0xFFFFFFFF therefore reads back 0x00FF1F01. With no write, the register holds its value.
- R3: Sense code 0 (level high): the request equals the synchronised pin.
- R4: Sense code 3 (level low): the request equals the inverse of the synchronised pin.
- R5: Sense code 1 (rising edge): a 0-to-1 transition of the synchronised pin sets the line's latch. The latch stays set after the pin returns to 0, and the request follows the latch.
- R6: Sense code 2 (falling edge): a 1-to-0 transition sets the latch, and the request follows the latch. A rising transition alone leaves the request at 0.
- R7: A write with bit 27-n set clears the latch of line n only. A write with that bit at 0 leaves the latch unchanged. A later edge sets the latch again. When a clear and an edge meet in the same cycle, the clear wins.
- R8: A write that changes a line's sense code clears that line's latch. A write that repeats the same code keeps the latch.
- R9: A request is 1 only when both the line enable and the master enable are 1. Latches keep capturing edges while a line is gated, so a pending edge appears as soon as the line is enabled.
- R10: `crit_req` carries the line 0 request. `main_req[k-1]` carries the line k request for k = 1 to 3.
- R11: A pin change reaches a level-mode request after exactly two rising clock edges.
- R12: `crit_normal` reflects register bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read value |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| line_req | output | 4 | Conditioned, gated request per line |
| crit_req | output | 1 | Critical-group request (line 0) |
| main_req | output | 3 | Main-group requests (lines 1 to 3) |
| crit_normal | output | 1 | Critical interrupt routing select |

## Verification
The bench builds the block with its default parameters: four lines and a two-stage synchroniser, which matches the fixed register layout. That configuration is small enough to sweep every line against every sense code and every combination of line and master enable, across a low-high-low pin pattern. A re-enable step then exposes edges captured while gated. Separate directed sequences pin down the exact two-edge latency, the per-line latch clear, clearing on a sense change, and the register read-back mask.

// File: rtl/extint_pkg.sv
// Package: shared types, constants and bit-position helpers for the
// external interrupt sense controller. Assumes a 32-bit control register
// with at most four lines, as fixed by the register layout.
package extint_pkg;

    localparam int CTRL_W    = 32;
    localparam int MAX_LINES = 4;
    localparam int MEE_BIT   = 12;
    localparam int ROUTE_BIT = 0;

    typedef enum logic [1:0] {
        SENSE_HIGH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   en;
    } line_cfg_t;

    // Lowest bit of the sense field of line n
    function automatic int sense_lsb(input int n);
        return 22 - 2 * n;
    endfunction

    // Enable bit of line n
    function automatic int en_bit(input int n);
        return 11 - n;
    endfunction

    // Write-one-to-clear bit of line n
    function automatic int clr_bit(input int n);
        return 27 - n;
    endfunction

    // Mask of bits that hold state and read back
    function automatic logic [CTRL_W-1:0] stored_mask(input int nlines);
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int n = 0; n < nlines; n++) begin
            m[sense_lsb(n)]     = 1'b1;
            m[sense_lsb(n) + 1] = 1'b1;
            m[en_bit(n)]        = 1'b1;
        end
        m[MEE_BIT]   = 1'b1;
        m[ROUTE_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/extint_sync.sv
// Module: multi-flop synchroniser for one asynchronous pin.
// Assumes STAGES >= 2 and a pin that may change at any time.
// Resets every stage to 0.
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stg_q;
    logic              armed_q;

    // Shift the pin through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
    end

    // Marks cycles whose previous edge was a normal (non-reset) shift
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign q_o = stg_q[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        stg_q[0] == $past(d_i)); // R11

    for (genvar i = 1; i < STAGES; i++) begin : g_stage_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
            stg_q[i] == $past(stg_q[i-1])); // R11
    end

endmodule

// File: rtl/extint_ctrl_reg.sv
// Module: the single control register. It holds the sense code and enable
// of each line, the master enable and the routing select. It produces
// per-line clear pulses from the write-one-to-clear bits, and sense-change
// pulses when a write alters a line's code. Assumes NUM_LINES <= 4.
module extint_ctrl_reg
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [CTRL_W-1:0]               wr_data,
    output line_cfg_t [NUM_LINES-1:0]       cfg_o,
    output logic [NUM_LINES-1:0]            clr_o,
    output logic [NUM_LINES-1:0]            chg_o,
    output logic                            mee_o,
    output logic                            route_o,
    output logic [CTRL_W-1:0]               rd_data_o
);

    localparam logic [CTRL_W-1:0] KEEP_MASK = stored_mask(NUM_LINES);

    line_cfg_t [NUM_LINES-1:0] cfg_q;
    logic                      mee_q;
    logic                      route_q;
    logic                      wr_unused;

    // Capture all stored fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            mee_q   <= 1'b0;
            route_q <= 1'b0;
        end else if (wr_en) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                cfg_q[n].sense <= sense_e'(wr_data[sense_lsb(n) +: 2]);
                cfg_q[n].en    <= wr_data[en_bit(n)];
            end
            mee_q   <= wr_data[MEE_BIT];
            route_q <= wr_data[ROUTE_BIT];
        end
    end

    // Per-line clear and sense-change pulses
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_pulse
        assign clr_o[n] = wr_en & wr_data[clr_bit(n)];
        assign chg_o[n] = wr_en & (wr_data[sense_lsb(n) +: 2] != cfg_q[n].sense);
    end

    // Assemble the read value; clear bits and spare bits read 0
    always_comb begin
        rd_data_o = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            rd_data_o[sense_lsb(n) +: 2] = cfg_q[n].sense;
            rd_data_o[en_bit(n)]         = cfg_q[n].en;
        end
        rd_data_o[MEE_BIT]   = mee_q;
        rd_data_o[ROUTE_BIT] = route_q;
    end

    assign cfg_o     = cfg_q;
    assign mee_o     = mee_q;
    assign route_o   = route_q;
    assign wr_unused = ^(wr_data & ~KEEP_MASK);

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data_o == ($past(wr_data) & KEEP_MASK)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data_o)); // R2

endmodule

// File: rtl/extint_line.sv
// Module: conditioning for one interrupt line. It synchronises the pin,
// detects edges against the previous synchronised value, keeps a sticky
// edge latch, selects level or latch by sense code and gates the result.
// Assumes clear and sense-change pulses last one cycle; clear beats a
// coincident edge.
module extint_line
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  sense_e sense_i,
    input  logic   en_i,
    input  logic   mee_i,
    input  logic   clr_i,
    input  logic   chg_i,
    output logic   req_o
);

    logic s_sync;
    logic s_prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic raw;

    extint_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (s_sync)
    );

    // Remember the previous synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) s_prev_q <= 1'b0;
        else        s_prev_q <= s_sync;
    end

    assign rise = s_sync & ~s_prev_q;
    assign fall = ~s_sync & s_prev_q;

    // Sticky edge latch: clear or sense change first, then capture
    always_ff @(posedge clk) begin
        if (!rst_n)                                   latch_q <= 1'b0;
        else if (clr_i || chg_i)                      latch_q <= 1'b0;
        else if ((sense_i == SENSE_RISE && rise) ||
                 (sense_i == SENSE_FALL && fall))     latch_q <= 1'b1;
    end

    // Choose level or latched event by sense code
    always_comb begin
        unique case (sense_i)
            SENSE_HIGH: raw = s_sync;
            SENSE_LOW:  raw = ~s_sync;
            default:    raw = latch_q;
        endcase
    end

    assign req_o = raw & en_i & mee_i;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i && !chg_i) |=> latch_q); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !latch_q); // R7
    AST_SENSE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> !latch_q); // R8
    AST_LATCH_EDGE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> (sense_i == SENSE_RISE || sense_i == SENSE_FALL)); // R6

endmodule

// File: rtl/extint_sense_ctrl.sv
// Module: top of the external interrupt sense controller. It connects
// the control register to one conditioning slice per line and splits the
// line requests into the critical group (line 0) and the main group
// (lines 1 to 3). Assumes NUM_LINES is 4, as fixed by the register layout.
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    input  logic [NUM_LINES-1:0] ext_pin,
    output logic [NUM_LINES-1:0] line_req,
    output logic                 crit_req,
    output logic [NUM_LINES-2:0] main_req,
    output logic                 crit_normal
);

    line_cfg_t [NUM_LINES-1:0] cfg;
    logic [NUM_LINES-1:0]      clr;
    logic [NUM_LINES-1:0]      chg;
    logic [NUM_LINES-1:0]      en_vec;
    logic                      mee;

    extint_ctrl_reg #(.NUM_LINES(NUM_LINES)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg_o     (cfg),
        .clr_o     (clr),
        .chg_o     (chg),
        .mee_o     (mee),
        .route_o   (crit_normal),
        .rd_data_o (rd_data)
    );

    // One conditioning slice per line
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign en_vec[n] = cfg[n].en;
        extint_line #(.SYNC_STAGES(SYNC_STAGES)) line_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (ext_pin[n]),
            .sense_i (cfg[n].sense),
            .en_i    (cfg[n].en),
            .mee_i   (mee),
            .clr_i   (clr[n]),
            .chg_i   (chg[n]),
            .req_o   (line_req[n])
        );
    end

    assign crit_req = line_req[0];
    assign main_req = line_req[NUM_LINES-1:1];

    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req & ~en_vec) == '0); // R9
    AST_MASTER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mee |-> line_req == '0); // R9
    AST_ROUTE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> crit_normal == $past(wr_data[0])); // R12

endmodule

// File: tb/extint_sense_ctrl_tb.sv
module extint_sense_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  ext_pin = '0;
    logic [3:0]  line_req;
    logic        crit_req;
    logic [2:0]  main_req;
    logic        crit_normal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    extint_sense_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .ext_pin     (ext_pin),
        .line_req    (line_req),
        .crit_req    (crit_req),
        .main_req    (main_req),
        .crit_normal (crit_normal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Line n field: sense code at 23-2n:22-2n, enable at 11-n
    function automatic logic [31:0] fld(input int n, input int code, input bit en);
        return (32'(code) << (22 - 2*n)) | (32'(en) << (11 - n));
    endfunction

    function automatic logic [31:0] clrb(input int n);
        return 32'd1 << (27 - n);
    endfunction

    localparam logic [31:0] MEE = 32'h0000_1000;

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_req(input string tag, input logic [3:0] exp);
        check(tag, {28'd0, line_req}, {28'd0, exp});
        check("R10 group mapping", {27'd0, main_req, crit_req}, {27'd0, line_req[3:1], line_req[0]});
    endtask

    // Expected ungated request from sense code, pin and latch state
    function automatic bit model(input int code, input bit pin, input bit latched);
        case (code)
            0: return pin;
            3: return !pin;
            default: return latched;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset rd_data", rd_data, 32'h0);
        check("R1 reset requests", {24'd0, line_req, main_req, crit_req}, 32'h0);
        check("R1 reset crit_normal", {31'd0, crit_normal}, 32'h0);

        // R2 layout per line and code
        for (int n = 0; n < 4; n++) begin
            for (int c = 0; c < 4; c++) begin
                write_reg(fld(n, c, 1'b1) | clrb(n));
                check("R2 field readback", rd_data, fld(n, c, 1'b1));
            end
        end
        write_reg(32'hFFFF_FFFF);
        check("R2 full write mask", rd_data, 32'h00FF_1F01);
        repeat (3) @(negedge clk);
        check("R2 hold without write", rd_data, 32'h00FF_1F01);
        write_reg(32'h0);

        // R3 R4 R5 R6 R9: sweep line, code, enable, master enable
        for (int n = 0; n < 4; n++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int e = 0; e < 2; e++) begin
                        bit g;
                        bit lat;
                        g = (m == 1) && (e == 1);
                        ext_pin = '0;
                        settle();
                        write_reg(fld(n, c, e[0]) | (m[0] ? MEE : 32'h0) | clrb(n));
                        settle();
                        lat = 1'b0;
                        check_req("R3/R4 sweep pin low", 4'(g & model(c, 1'b0, lat)) << n);
                        ext_pin[n] = 1'b1;
                        settle();
                        if (c == 1) lat = 1'b1;
                        check_req("R5 sweep pin high", 4'(g & model(c, 1'b1, lat)) << n);
                        ext_pin[n] = 1'b0;
                        settle();
                        if (c == 2) lat = 1'b1;
                        check_req("R6 sweep pin low again", 4'(g & model(c, 1'b0, lat)) << n);
                        if (!g) begin
                            write_reg(fld(n, c, 1'b1) | MEE);
                            settle();
                            check_req("R9 edge kept while gated", 4'(model(c, 1'b0, lat)) << n);
                        end
                    end
                end
            end
        end

        // R7 per-line clear
        ext_pin = '0;
        write_reg(fld(1, 1, 1'b1) | fld(2, 1, 1'b1) | MEE | clrb(1) | clrb(2));
        settle();
        ext_pin = 4'b0110;
        settle();
        check_req("R7 both latched", 4'b0110);
        write_reg(fld(1, 1, 1'b1) | fld(2, 1, 1'b1) | MEE | clrb(1));
        settle();
        check_req("R7 clear line 1 only", 4'b0100);
        write_reg(fld(1, 1, 1'b1) | fld(2, 1, 1'b1) | MEE);
        settle();
        check_req("R7 zero clear bits no effect", 4'b0100);
        ext_pin[1] = 1'b0;
        settle();
        ext_pin[1] = 1'b1;
        settle();
        check_req("R7 relatch after new edge", 4'b0110);

        // R8 sense change clears, same code keeps
        ext_pin = 4'b1000;
        write_reg(fld(3, 2, 1'b1) | MEE | clrb(3));
        settle();
        ext_pin = 4'b0000;
        settle();
        check_req("R8 falling latched", 4'b1000);
        write_reg(fld(3, 2, 1'b1) | MEE);
        settle();
        check_req("R8 same code keeps latch", 4'b1000);
        write_reg(fld(3, 1, 1'b1) | MEE);
        settle();
        check_req("R8 code change clears latch", 4'b0000);

        // R11 exact latency in level-high mode
        write_reg(fld(0, 0, 1'b1) | MEE);
        settle();
        check_req("R11 idle", 4'b0000);
        ext_pin[0] = 1'b1;
        @(negedge clk);
        check_req("R11 after one edge", 4'b0000);
        @(negedge clk);
        check_req("R11 after two edges", 4'b0001);
        ext_pin[0] = 1'b0;
        @(negedge clk);
        check_req("R11 fall after one edge", 4'b0001);
        @(negedge clk);
        check_req("R11 fall after two edges", 4'b0000);

        // R12 routing select
        write_reg(32'h0000_0001);
        check("R12 routing set", {31'd0, crit_normal}, 32'd1);
        write_reg(32'h0);
        check("R12 routing clear", {31'd0, crit_normal}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule